// File: doc/BRIEF.md
# Light-Level Window Alarm with Persistence Filter

This block watches a stream of 16-bit light conversion results and raises an alarm when the light level stays outside a programmable window for long enough. Each result arrives with a one-cycle valid pulse. The block compares the result with an upper limit and a lower limit. Each limit is a single byte that forms the upper half of a 16-bit compare value, and the lower half of that value is always zero.

A run counter counts consecutive out-of-window results. Any in-window result resets it to zero. A 2-bit persistence code sets how long a run must be before the alarm fires. The alarm is a sticky flag. It also drives the enable of an active-low, open-drain interrupt pin, which pulls the line low while the flag is set. The flag stays set until the host clears it. The host can clear it by writing a zero to the flag bit or by pulsing a separate clear strobe. Bus decoding and the threshold registers themselves are outside this block.

Top module: `light_alarm`

## Requirements
- R1: The upper compare value is `{upper_thr_i, 8'h00}`. A valid result strictly greater than it is out of window, and a result equal to it is in window.
- R2: The lower compare value is `{lower_thr_i, 8'h00}`. A valid result strictly less than it is out of window, and a result equal to it is in window.
- R3: `persist_i` codes 0, 1, 2 and 3 need a run of 1, 4, 8 and 16 consecutive valid out-of-window results. The flag is set on the clock edge that accepts the result completing the run, and it is visible from the next cycle.
- R4: A valid in-window result resets the run count to zero, so a later run starts counting again from one.
- R5: While `result_valid_i` is low, `result_i` has no effect on the run count or on the flag.
- R6: Once set, the flag stays set whatever results follow, until a clear arrives.
- R7: A high level on `flag_wr_zero_i` or on `clear_i` clears the flag from the next cycle on.
- R8: If a clear and a trigger happen in the same cycle, the trigger wins and the flag stays set.
- R9: The run count saturates at 16. After a run longer than 16, clearing the flag and then receiving one more out-of-window result sets the flag again at once, for any persistence code.
- R10: `irq_oe_o` is high exactly when `flag_o` is high. After reset both are low.
- R11: With the default limit bytes 0xFF (upper) and 0x00 (lower), only results above 0xFF00 set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 16 | Conversion result |
| result_valid_i | input | 1 | One-cycle pulse marking a new result |
| upper_thr_i | input | 8 | Upper limit byte (upper half of the compare value) |
| lower_thr_i | input | 8 | Lower limit byte (upper half of the compare value) |
| persist_i | input | 2 | Persistence code: 0/1/2/3 selects a run of 1/4/8/16 |
| flag_wr_zero_i | input | 1 | Host writes zero to the flag bit |
| clear_i | input | 1 | Clear-alarm strobe |
| flag_o | output | 1 | Sticky alarm flag |
| irq_oe_o | output | 1 | Pull-down enable for the active-low interrupt pin |

## Verification
The assertions check the following on every cycle: the flag stays set until a clear, it drops only after a clear, it rises only on a valid result, and it follows at once from a single out-of-window result under code 0, even when a clear arrives in the same cycle. They also check that the run count never goes above 16 and that a valid in-window result returns it to zero. Other behaviour can only be shown by the bench's scenarios: the exact run lengths for codes 1 to 3, the equality boundaries of both limits, the window given by the default limit bytes, and the re-trigger that follows from a saturated run.

// File: rtl/light_alarm_pkg.sv
package light_alarm_pkg;

  typedef enum logic [1:0] {
    RUN_1  = 2'd0,
    RUN_4  = 2'd1,
    RUN_8  = 2'd2,
    RUN_16 = 2'd3
  } run_code_e;

  // Run length needed for a code: 1, then 2^(code+1)
  function automatic int unsigned run_len(run_code_e code);
    return (code == RUN_1) ? 1 : (1 << (int'(code) + 1));
  endfunction

endpackage

// File: rtl/light_alarm_window.sv
module light_alarm_window #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned THR_W  = 8
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic [THR_W-1:0]  upper_thr_i,
  input  logic [THR_W-1:0]  lower_thr_i,
  output logic              outside_o
);
  localparam int unsigned PAD_W = DATA_W - THR_W;

  logic [DATA_W-1:0] upper_full, lower_full;

  assign upper_full = {upper_thr_i, {PAD_W{1'b0}}};
  assign lower_full = {lower_thr_i, {PAD_W{1'b0}}};
  assign outside_o  = (result_i > upper_full) || (result_i < lower_full);
endmodule

// File: rtl/light_alarm_run.sv
module light_alarm_run
  import light_alarm_pkg::*;
#(
  parameter int unsigned MAX_RUN = 16,
  localparam int unsigned CNT_W  = $clog2(MAX_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             outside_i,
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] run_cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, need;

  assign cnt_inc = (cnt_q == CNT_W'(MAX_RUN)) ? cnt_q : cnt_q + 1'b1;
  assign need    = CNT_W'(run_len(run_code_e'(code_i)));
  assign hit_o   = valid_i && outside_i && (cnt_inc >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= outside_i ? cnt_inc : '0;
  end

  assign run_cnt_o = cnt_q;
endmodule

// File: rtl/light_alarm_flag.sv
module light_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/light_alarm.sv
module light_alarm #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned MAX_RUN = 16,
  localparam int unsigned CNT_W  = $clog2(MAX_RUN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_valid_i,
  input  logic [THR_W-1:0]  upper_thr_i,
  input  logic [THR_W-1:0]  lower_thr_i,
  input  logic [1:0]        persist_i,
  input  logic              flag_wr_zero_i,
  input  logic              clear_i,
  output logic              flag_o,
  output logic              irq_oe_o
);
  logic             outside, hit;
  logic [CNT_W-1:0] run_cnt;

  light_alarm_window #(.DATA_W(DATA_W), .THR_W(THR_W)) u_window (
    .result_i    (result_i),
    .upper_thr_i (upper_thr_i),
    .lower_thr_i (lower_thr_i),
    .outside_o   (outside)
  );

  light_alarm_run #(.MAX_RUN(MAX_RUN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (result_valid_i),
    .outside_i (outside),
    .code_i    (persist_i),
    .run_cnt_o (run_cnt),
    .hit_o     (hit)
  );

  light_alarm_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (flag_wr_zero_i | clear_i),
    .flag_o (flag_o)
  );

  // open-drain pin: enable pulls the line low
  assign irq_oe_o = flag_o;
endmodule

// File: rtl/light_alarm_chk.sv
module light_alarm_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned MAX_RUN = 16,
  parameter int unsigned CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] result_i,
  input logic              result_valid_i,
  input logic [THR_W-1:0]  upper_thr_i,
  input logic [THR_W-1:0]  lower_thr_i,
  input logic [1:0]        persist_i,
  input logic              flag_wr_zero_i,
  input logic              clear_i,
  input logic              flag_o,
  input logic [CNT_W-1:0]  run_cnt_i
);
  logic any_clr, oow;
  assign any_clr = flag_wr_zero_i | clear_i;
  assign oow = (result_i[DATA_W-1 -: THR_W] > upper_thr_i)
            || ((result_i[DATA_W-1 -: THR_W] == upper_thr_i) && (result_i[DATA_W-THR_W-1:0] != '0))
            || (result_i[DATA_W-1 -: THR_W] < lower_thr_i);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !any_clr |=> flag_o);

  assert_drop_needs_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(any_clr));

  assert_rise_needs_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(result_valid_i));

  assert_code0_fires_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_i && oow && persist_i == 2'd0 |=> flag_o);

  assert_trigger_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_i && oow && persist_i == 2'd0 && any_clr |=> flag_o);

  assert_run_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_i && !oow |=> run_cnt_i == '0);

  assert_run_saturates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_i <= CNT_W'(MAX_RUN));
endmodule

bind light_alarm light_alarm_chk #(
  .DATA_W(DATA_W), .THR_W(THR_W), .MAX_RUN(MAX_RUN), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .result_i       (result_i),
  .result_valid_i (result_valid_i),
  .upper_thr_i    (upper_thr_i),
  .lower_thr_i    (lower_thr_i),
  .persist_i      (persist_i),
  .flag_wr_zero_i (flag_wr_zero_i),
  .clear_i        (clear_i),
  .flag_o         (flag_o),
  .run_cnt_i      (run_cnt)
);

// File: tb/light_alarm_test.sv
module light_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] result = '0;
  logic        valid = 1'b0;
  logic [7:0]  upper = 8'hFF;
  logic [7:0]  lower = 8'h00;
  logic [1:0]  code = 2'd0;
  logic        wr_zero = 1'b0;
  logic        clr = 1'b0;
  logic        flag, oe;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  light_alarm uut (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result), .result_valid_i(valid),
    .upper_thr_i(upper), .lower_thr_i(lower), .persist_i(code),
    .flag_wr_zero_i(wr_zero), .clear_i(clr), .flag_o(flag), .irq_oe_o(oe)
  );

  typedef struct packed {
    logic        wz;
    logic [1:0]  code;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] res;
    logic        exp;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h80, 8'h20, 16'h5000, 1'b0}, // in window
    '{1'b0, 2'd0, 8'h80, 8'h20, 16'h8000, 1'b0}, // R1 equal upper
    '{1'b0, 2'd0, 8'h80, 8'h20, 16'h8001, 1'b1}, // R1 above
    '{1'b0, 2'd0, 8'h80, 8'h20, 16'h5000, 1'b1}, // R6 sticky
    '{1'b1, 2'd0, 8'h80, 8'h20, 16'h5000, 1'b0}, // R7 write zero
    '{1'b0, 2'd0, 8'h80, 8'h20, 16'h2000, 1'b0}, // R2 equal lower
    '{1'b0, 2'd0, 8'h80, 8'h20, 16'h1FFF, 1'b1}, // R2 below
    '{1'b1, 2'd1, 8'h80, 8'h20, 16'h5000, 1'b0}, // R4 run reset
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'hFFFF, 1'b0}, // R3 run 1
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h0000, 1'b0}, // run 2
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b0}, // run 3
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b1}, // R3 run 4
    '{1'b1, 2'd1, 8'h80, 8'h20, 16'h5000, 1'b0},
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b0},
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b0},
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h5000, 1'b0}, // R4 break
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b0},
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b0},
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b0},
    '{1'b0, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b1}, // R4 fresh run of 4
    '{1'b1, 2'd1, 8'h80, 8'h20, 16'h9000, 1'b1}, // R8 trigger beats clear
    '{1'b1, 2'd0, 8'hFF, 8'h00, 16'hFF00, 1'b0}, // R11 default edge
    '{1'b0, 2'd0, 8'hFF, 8'h00, 16'hFF01, 1'b1}  // R11 above default
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step(logic v, logic [15:0] r, logic wz, logic cs);
    @(negedge clk);
    valid = v; result = r; wr_zero = wz; clr = cs;
    @(negedge clk);
    valid = 1'b0; wr_zero = 1'b0; clr = 1'b0;
  endtask

  task automatic run_out(int n, string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 16'hF000, 1'b0, 1'b0);
      check(req, flag, (i == n - 1));
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset flag", flag, 1'b0);
    check("R10 reset pin", oe, 1'b0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      upper = VECS[k].hi; lower = VECS[k].lo; code = VECS[k].code;
      step(1'b1, VECS[k].res, VECS[k].wz, 1'b0);
      check($sformatf("R1/R2/R3/R4/R6/R7/R8/R11 vector %0d", k), flag, VECS[k].exp);
      check("R10 pin follows flag", oe, VECS[k].exp);
    end

    upper = 8'h80; lower = 8'h20;
    // R7 clear strobe without a result
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    check("R7 clear strobe", flag, 1'b0);
    // R5 invalid out-of-window result ignored
    code = 2'd0;
    step(1'b0, 16'hFFFF, 1'b0, 1'b0);
    check("R5 no valid", flag, 1'b0);
    // R3 code 2: run of 8
    code = 2'd2;
    step(1'b1, 16'h5000, 1'b0, 1'b0);
    run_out(8, "R3 run 8");
    // R3 code 3: run of 16, R5 gaps in valid do not break a run
    step(1'b1, 16'h5000, 1'b0, 1'b1);
    code = 2'd3;
    for (int i = 0; i < 15; i++) begin
      step(1'b1, 16'hF000, 1'b0, 1'b0);
      step(1'b0, 16'h5000, 1'b0, 1'b0);
    end
    check("R5 gaps keep run", flag, 1'b0);
    step(1'b1, 16'hF000, 1'b0, 1'b0);
    check("R3 run 16", flag, 1'b1);
    // R9 long run saturates, then re-trigger after clear
    for (int i = 0; i < 20; i++) step(1'b1, 16'hF000, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    check("R9 cleared", flag, 1'b0);
    step(1'b1, 16'hF000, 1'b0, 1'b0);
    check("R9 saturated retrigger", flag, 1'b1);
    // R10 reset mid-operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears flag", flag, 1'b0);
    check("R10 reset clears pin", oe, 1'b0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule